// File: doc/BRIEF.md
# Activity-adaptive scan shift pacer

This block paces the shifting of a built-in self-test scan chain of N flip-flops. A free-running base clock runs at the fastest rate the logic allows. The block emits a one-cycle shift-enable strobe every D base cycles, where D is one of M divide values, from M (slowest) down to 1 (one shift per cycle). The scan chain, the pattern source and the response compactor all take this one strobe as their common enable, so they always move together.

The choice of D follows the switching activity in the chain. The block keeps a shadow copy of the chain and a running count of adjacent flip-flop pairs that hold equal values. Equal neighbours do not toggle when the chain shifts, so a high count means low activity and permits a faster rate. A low count means heavy toggling and forces a slower rate. A scan-in starts on a start pulse, takes exactly N strobes and ends with a done pulse. A valid input lets the pattern source hold back a bit.

Top module: `scan_rate_ctrl`

## Requirements
- R1: Asynchronous reset gives `div_o` = M, `count_o` = 0, `busy_o` = 0, `shift_en_o` = 0 and `done_o` = 0. The shadow chain resets to an alternating pattern with 0 at the head (the entry position), 1 next to it, and so on.
- R2: On each strobe, `bit_i` enters the shadow chain at the head and every stored bit moves one place toward the tail. From the cycle after that strobe, `count_o` equals the number of adjacent equal pairs in the shadow chain (0 to N-1). Between strobes it holds its value.
- R3: The divide value is M minus the number of k in 1..M-1 for which count·M >= k·N. With N=8 and M=4 this gives counts 0-1 → 4, 2-3 → 3, 4-5 → 2 and 6-7 → 1.
- R4: While busy, each shift period lasts `div_o` base cycles, and the strobe comes in the last of them. The total length of a scan-in is the sum of its periods.
- R5: On a strobe, `div_o` loads the R3 value of the count after that shift. Between strobes it holds, so a period that has started is never shortened.
- R6: A start while idle sets `busy_o`, and `div_o` loads the R3 value of the current count. A start while busy has no effect.
- R7: `done_o` pulses for one cycle in the cycle after the N-th strobe of a scan-in. In that cycle `busy_o` is 0.
- R8: While `bit_valid_i` is 0 no strobe is issued. A period that has reached its last cycle waits there, and the strobe comes in the first cycle in which valid is 1 again.
- R9: For N=8 and M=4, the first scan-in after reset with the bits 1,0,0,0,0,0,0,1 runs 4 periods of 4 cycles, 2 of 3 and 2 of 2, which is 26 cycles, against 32 at the uniform slowest rate.
- R10: A repeated 1,0 pattern keeps every period at M cycles, also on a second scan-in. A repeated 1,1,1,0,0,0 pattern makes the second scan-in shorter than N·M cycles.
- R11: A start in the same cycle as `done_o` is accepted, and the next scan-in follows without an idle gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Base clock at the fastest rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a scan-in of N shifts |
| bit_valid_i | input | 1 | Pattern source has a bit ready |
| bit_i | input | 1 | Bit entering the chain at the next strobe |
| shift_en_o | output | 1 | Shift strobe for chain, source and compactor |
| div_o | output | $clog2(M+1) | Divide value of the current period |
| count_o | output | $clog2(N) | Running count of equal adjacent pairs |
| busy_o | output | 1 | Scan-in in progress |
| done_o | output | 1 | One-cycle pulse after the last shift |

## Verification
Two functions can fall in the same cycle: the done pulse that closes one scan-in and the start that opens the next. The bench raises start exactly in the done cycle and expects the new scan-in to begin on that edge. It also expects the first period of the new scan-in to use the divide value of the count left by the last shift of the old one. A start raised in the middle of a busy period is also checked, and it must leave both the period lengths and the total unchanged.

// File: rtl/scan_rate_pkg.sv
package scan_rate_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} run_state_e;
endpackage

// File: rtl/scan_rate_shadow.sv
module scan_rate_shadow #(
  parameter int unsigned N  = 8,
  parameter int unsigned CW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          shift_i,
  input  logic          bit_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] cnt_next_o
);
  function automatic logic [N-1:0] alt_fill();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = (i % 2) == 1;
    return v;
  endfunction

  localparam logic [N-1:0] RST_PAT = alt_fill();

  logic [N-1:0]  chain_q;
  logic [CW-1:0] cnt_q;
  logic          gain, loss;

  // entering pair at head, departing pair at tail
  assign gain       = bit_i == chain_q[0];
  assign loss       = chain_q[N-1] == chain_q[N-2];
  assign cnt_next_o = cnt_q + CW'(gain) - CW'(loss);
  assign cnt_o      = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= RST_PAT;
      cnt_q   <= '0;
    end else if (shift_i) begin
      chain_q <= {chain_q[N-2:0], bit_i};
      cnt_q   <= cnt_next_o;
    end
  end
endmodule

// File: rtl/scan_rate_band.sv
module scan_rate_band #(
  parameter int unsigned N  = 8,
  parameter int unsigned M  = 4,
  parameter int unsigned CW = 3,
  parameter int unsigned DW = 3
) (
  input  logic [CW-1:0] cnt_i,
  output logic [DW-1:0] div_o
);
  logic [M-2:0] above;

  for (genvar k = 1; k < M; k++) begin : g_thr
    assign above[k-1] = (32'(cnt_i) * 32'(M)) >= 32'(k * N);
  end

  assign div_o = DW'(M) - DW'($countones(above));
endmodule

// File: rtl/scan_rate_pacer.sv
module scan_rate_pacer
  import scan_rate_pkg::*;
#(
  parameter int unsigned N  = 8,
  parameter int unsigned M  = 4,
  parameter int unsigned DW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          valid_i,
  input  logic [DW-1:0] div_sel_i,
  output logic          shift_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] div_o
);
  localparam int unsigned PW = (M > 2) ? $clog2(M) : 1;
  localparam int unsigned SW = (N > 2) ? $clog2(N) : 1;

  run_state_e    state_q;
  logic [PW-1:0] ph_q;
  logic [SW-1:0] sc_q;
  logic [DW-1:0] div_q;
  logic          done_q;
  logic          at_end, last_shift;

  assign at_end     = 32'(ph_q) == 32'(div_q) - 32'd1;
  assign shift_o    = (state_q == ST_RUN) && valid_i && at_end;
  assign last_shift = 32'(sc_q) == N - 1;
  assign busy_o     = state_q == ST_RUN;
  assign done_o     = done_q;
  assign div_o      = div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ph_q    <= '0;
      sc_q    <= '0;
      div_q   <= DW'(M);
      done_q  <= 1'b0;
    end else begin
      done_q <= shift_o && last_shift;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_RUN;
          ph_q    <= '0;
          sc_q    <= '0;
          div_q   <= div_sel_i;
        end
        ST_RUN: begin
          if (shift_o) begin
            ph_q  <= '0;
            div_q <= div_sel_i;
            if (last_shift) begin
              state_q <= ST_IDLE;
              sc_q    <= '0;
            end else begin
              sc_q <= sc_q + 1'b1;
            end
          end else if (!at_end) begin
            ph_q <= ph_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/scan_rate_ctrl.sv
module scan_rate_ctrl #(
  parameter  int unsigned N  = 8,
  parameter  int unsigned M  = 4,
  localparam int unsigned CW = $clog2(N),
  localparam int unsigned DW = $clog2(M + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          bit_valid_i,
  input  logic          bit_i,
  output logic          shift_en_o,
  output logic [DW-1:0] div_o,
  output logic [CW-1:0] count_o,
  output logic          busy_o,
  output logic          done_o
);
  logic [CW-1:0] cnt, cnt_next, cnt_sel;
  logic [DW-1:0] div_sel;
  logic          shift;

  scan_rate_shadow #(.N(N), .CW(CW)) i_shadow (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_i    (shift),
    .bit_i      (bit_i),
    .cnt_o      (cnt),
    .cnt_next_o (cnt_next)
  );

  // on a strobe the next period follows the post-shift count
  assign cnt_sel = shift ? cnt_next : cnt;

  scan_rate_band #(.N(N), .M(M), .CW(CW), .DW(DW)) i_band (
    .cnt_i (cnt_sel),
    .div_o (div_sel)
  );

  scan_rate_pacer #(.N(N), .M(M), .DW(DW)) i_pacer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .valid_i   (bit_valid_i),
    .div_sel_i (div_sel),
    .shift_o   (shift),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .div_o     (div_o)
  );

  assign shift_en_o = shift;
  assign count_o    = cnt;
endmodule

// File: rtl/scan_rate_ctrl_chk.sv
module scan_rate_ctrl_chk #(
  parameter int unsigned N  = 8,
  parameter int unsigned M  = 4,
  parameter int unsigned CW = 3,
  parameter int unsigned DW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          bit_valid_i,
  input logic          bit_i,
  input logic          shift_en_o,
  input logic [DW-1:0] div_o,
  input logic [CW-1:0] count_o,
  input logic          busy_o,
  input logic          done_o
);
  p_div_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_o >= DW'(1)) && (32'(div_o) <= M));

  p_count_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(count_o) <= N - 1);

  p_count_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_en_o |=> $stable(count_o));

  p_count_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_en_o |=> (count_o == $past(count_o)) ||
                   (count_o == $past(count_o) + 1'b1) ||
                   (count_o == $past(count_o) - 1'b1));

  p_div_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !shift_en_o |=> $stable(div_o));

  p_strobe_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_en_o |-> bit_valid_i && busy_o);

  p_done_after_shift_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(shift_en_o) && !busy_o);

  p_busy_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !start_i |=> !busy_o);
endmodule

bind scan_rate_ctrl scan_rate_ctrl_chk #(.N(N), .M(M), .CW(CW), .DW(DW)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .bit_valid_i (bit_valid_i),
  .bit_i       (bit_i),
  .shift_en_o  (shift_en_o),
  .div_o       (div_o),
  .count_o     (count_o),
  .busy_o      (busy_o),
  .done_o      (done_o)
);

// File: tb/test_scan_rate_ctrl.sv
`timescale 1ns/1ps
module test_scan_rate_ctrl;
  localparam int N = 8;
  localparam int M = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic       bit_valid_i = 1'b1;
  logic       bit_i = 1'b0;
  logic       shift_en_o, busy_o, done_o;
  logic [2:0] div_o;
  logic [2:0] count_o;

  int n_chk = 0;
  int n_err = 0;
  logic [N-1:0] m_sh;
  bit finished = 0;

  always #5 clk_i = ~clk_i;

  scan_rate_ctrl #(.N(N), .M(M)) i_scan_rate_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .bit_valid_i(bit_valid_i), .bit_i(bit_i), .shift_en_o(shift_en_o),
    .div_o(div_o), .count_o(count_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int recount(input logic [N-1:0] s);
    int c = 0;
    for (int i = 0; i < N - 1; i++) if (s[i] == s[i+1]) c++;
    return c;
  endfunction

  function automatic int mdiv(input int c);
    int b = 0;
    for (int k = 1; k < M; k++) if (c * M >= k * N) b++;
    return M - b;
  endfunction

  function automatic logic [N-1:0] alt_reset();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = (i % 2) == 1;
    return v;
  endfunction

  task automatic do_reset();
    rst_ni = 1'b0; start_i = 1'b0; bit_valid_i = 1'b1; bit_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    m_sh = alt_reset();
    @(negedge clk_i);
  endtask

  // Called at a negedge; returns at the negedge of the done cycle.
  task automatic run_scan(input logic [N-1:0] pat, input int stall_at, input int stall_len,
                          input int poke_at, output int total);
    int cyc = 0, k = 0, ph = 0, stl = 0, exp_total = 0, m_div, per;
    bit shifted;
    m_div = mdiv(recount(m_sh));
    start_i = 1'b1; bit_valid_i = 1'b1; bit_i = pat[0];
    @(negedge clk_i);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R6 start sets busy", busy_o, 1);
    while (k < N && cyc < 1000) begin
      if (ph == 0) begin
        per = m_div;
        if (k == stall_at) begin
          stl = stall_len;
          if (stall_len + 1 > per) per = stall_len + 1;
        end
        exp_total += per;
      end
      bit_valid_i = (stl == 0);
      start_i = (k == poke_at && ph == 1);
      #1;
      cyc++;
      shifted = shift_en_o;
      if (shifted) begin
        chk(div_o == 3'(m_div), "R5 divide of period", div_o, m_div);
        chk(ph + 1 == per, "R4 R8 period length", ph + 1, per);
        m_sh = {m_sh[N-2:0], pat[k]};
        m_div = mdiv(recount(m_sh));
        k++; ph = 0;
      end else begin
        ph++;
      end
      if (stl > 0) stl--;
      @(negedge clk_i);
      start_i = 1'b0;
      if (shifted) begin
        chk(count_o == 3'(recount(m_sh)), "R2 running count", count_o, recount(m_sh));
        if (k < N) bit_i = pat[k];
      end
    end
    if (cyc >= 1000) chk(0, "R4 scan did not finish", cyc, exp_total);
    chk(done_o == 1'b1 && busy_o == 1'b0, "R7 done pulse", {done_o, busy_o}, 2);
    chk(cyc == exp_total, "R4 scan-in length", cyc, exp_total);
    total = cyc;
  endtask

  task automatic t_reset();
    do_reset();
    chk(div_o == 3'(M), "R1 div after reset", div_o, M);
    chk(count_o == 0, "R1 count after reset", count_o, 0);
    chk({busy_o, shift_en_o, done_o} == 3'b000, "R1 idle outputs", {busy_o, shift_en_o, done_o}, 0);
  endtask

  task automatic t_example();
    int tot;
    do_reset();
    run_scan(8'b1000_0001, -1, 0, -1, tot);
    chk(tot == 26, "R9 example scan-in", tot, 26);
    chk(mdiv(3) == 3 && mdiv(4) == 2 && mdiv(6) == 1, "R3 band table", mdiv(6), 1);
    @(negedge clk_i);
    chk(done_o == 1'b0, "R7 done is one cycle", done_o, 0);
  endtask

  task automatic t_alternating();
    int tot;
    do_reset();
    run_scan(8'b0101_0101, -1, 0, -1, tot);
    chk(tot == N * M, "R10 alternating pass 1", tot, N * M);
    @(negedge clk_i);
    run_scan(8'b0101_0101, -1, 0, -1, tot);
    chk(tot == N * M, "R10 alternating pass 2", tot, N * M);
    chk(div_o == 3'(M), "R10 alternating stays slowest", div_o, M);
  endtask

  task automatic t_blocks();
    int tot;
    do_reset();
    run_scan(8'b1100_0111, -1, 0, -1, tot);
    @(negedge clk_i);
    run_scan(8'b1100_0111, -1, 0, -1, tot);
    chk(tot < N * M, "R10 low-activity pass faster", tot, N * M - 1);
  endtask

  task automatic t_stall();
    int tot;
    do_reset();
    run_scan(8'b1000_0001, 4, 6, -1, tot);
    chk(tot == 26 + 4, "R8 stall extends scan-in", tot, 30);
  endtask

  task automatic t_poke();
    int tot;
    do_reset();
    run_scan(8'b1000_0001, -1, 0, 1, tot);
    chk(tot == 26, "R6 start while busy ignored", tot, 26);
  endtask

  task automatic t_back_to_back();
    int tot;
    do_reset();
    run_scan(8'b1100_0111, -1, 0, -1, tot);
    run_scan(8'b1000_0001, -1, 0, -1, tot);
    chk(busy_o == 1'b0, "R11 second scan-in completed", busy_o, 0);
  endtask

  initial begin
    t_reset();
    t_example();
    t_alternating();
    t_blocks();
    t_stall();
    t_poke();
    t_back_to_back();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end
endmodule